// File: doc/BRIEF.md
# Address-Masked GPIO Controller

This block is an 8-pin general-purpose I/O peripheral on an APB-style register bus. Each pin is set as an input or an output by a direction register. The data register has no single address. Instead it fills a window of word addresses. The eight word-address bits used to reach it act as a per-pin mask, for writes and for reads alike. Software can therefore drive or sample any subset of pins with one bus access and no read-modify-write.

Output pins drive their pads, and each pad has an active-low output enable. Input pins pass through a synchronizer before they can be read. Larger pin counts are built by placing several instances side by side, each in its own 4 KB slot.

Top module: `gpio_mask_ctrl`

## Requirements
- R1: After reset all data bits are 0 and all direction bits are 0, so every pin is an input, `gpio_oe_n` is 0xFF and `gpio_out` is 0x00.
- R2: A write to the data window (byte offsets 0x000–0x3FC, `paddr[11:10]`=0, `paddr[1:0]`=0) updates data bit n to `pwdata[n]` only where mask bit n (`paddr[2+n]`) is 1. Every other data bit keeps its value.
- R3: A read from the data window returns 0 in every bit whose mask bit is 0.
- R4: In a data-window read, a pin whose direction bit is 1 (output) returns the last value written to its data bit, wherever its mask bit is 1.
- R5: In a data-window read, a pin whose direction bit is 0 (input) returns its `gpio_in` level. That level passes through a two-flop synchronizer: a change becomes visible after the second rising clock edge following it, and it is not visible after the first.
- R6: `gpio_out[n]` equals data bit n while direction bit n is 1, and is 0 otherwise. `gpio_oe_n[n]` is the inverse of direction bit n.
- R7: The direction register sits at byte offset 0x400. Writes load all 8 bits, and reads return them. A 1 means output.
- R8: A data write at offset 0x000 (all-zero mask) changes nothing, and a read there returns 0x00.
- R9: Registers change only on the rising edge that ends an access phase (`psel`=1, `penable`=1, `pwrite`=1). A setup phase alone changes nothing.
- R10: An access to any other address (offsets above 0x400, or `paddr[1:0]`≠0) writes nothing and reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB slot |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while a read is selected |
| gpio_in | input | 8 | Pad input levels (asynchronous) |
| gpio_out | output | 8 | Pad output values |
| gpio_oe_n | output | 8 | Active-low pad output enables |

## Verification
Two things can fall in the same cycle: a masked data write, and a change of the pad inputs or a direction flip that alters what the same bits read back. The bench provokes this in two ways. It issues writes with random masks while random `gpio_in` values are in flight through the synchronizer. It also flips direction bits just before masked reads. A bench model that tracks data, direction and the settled input level predicts every read, and every `gpio_out`/`gpio_oe_n` value. A directed sequence holds a read open across two edges to pin down the input latency exactly.

// File: rtl/gmc_pkg.sv
package gmc_pkg;
   typedef enum logic [1:0] {
      GMC_SEL_NONE = 2'd0,
      GMC_SEL_DATA = 2'd1,
      GMC_SEL_DIR  = 2'd2
   } gmc_sel_e;
endpackage

// File: rtl/gmc_decode.sv
module gmc_decode
   import gmc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NPINS      = 8,
   parameter int MASK_LSB   = 2,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output gmc_sel_e          sel,
   output logic [NPINS-1:0]  mask,
   output logic              wr_data,
   output logic              wr_dir,
   output logic              rd_en
);
   localparam int MASK_HI = MASK_LSB + NPINS;
   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFFSET);

   generate
      if (MASK_HI >= ADDR_W) begin : g_bad_width
         $error("gmc_decode: mask field does not fit in the address");
      end
      if ((DIR_OFFSET >> MASK_HI) == 0) begin : g_bad_dir
         $error("gmc_decode: direction register overlaps the data window");
      end
   endgenerate

   logic aligned;
   logic in_window;
   logic dir_hit;
   logic access;

   assign aligned   = (paddr[MASK_LSB-1:0] == '0);
   assign in_window = aligned && (paddr[ADDR_W-1:MASK_HI] == '0);
   assign dir_hit   = aligned && (paddr[ADDR_W-1:MASK_LSB] == DIR_A[ADDR_W-1:MASK_LSB]);
   assign mask      = paddr[MASK_HI-1:MASK_LSB];
   assign access    = psel && penable;

   always_comb begin
      if (in_window)    sel = GMC_SEL_DATA;
      else if (dir_hit) sel = GMC_SEL_DIR;
      else              sel = GMC_SEL_NONE;
   end

   assign wr_data = access && pwrite && (sel == GMC_SEL_DATA);
   assign wr_dir  = access && pwrite && (sel == GMC_SEL_DIR);
   assign rd_en   = psel && !pwrite;
endmodule

// File: rtl/gmc_sync.sv
module gmc_sync #(
   parameter int NPINS  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] async_in,
   output logic [NPINS-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gmc_sync: at least two stages are needed");
      end
   endgenerate

   logic [STAGES-1:0][NPINS-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign sync_out = stg[STAGES-1];

   // R5: the output follows the first stage one edge later (for two stages)
   a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (STAGES == 2) |=> (sync_out == $past(stg[0])));
endmodule

// File: rtl/gmc_regs.sv
module gmc_regs #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_data,
   input  logic             wr_dir,
   input  logic [NPINS-1:0] mask,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] dir_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (wr_data) data_q <= (data_q & ~mask) | (wdata & mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wdata;
   end

   a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> ((data_q & ~$past(mask)) == ($past(data_q) & ~$past(mask))));
   a_r2_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> ((data_q & $past(mask)) == ($past(wdata) & $past(mask))));
   a_r9_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data |=> $stable(data_q));
   a_r7_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(dir_q));
   a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_data && wr_dir));
endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
   import gmc_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int NPINS       = 8,
   parameter int MASK_LSB    = 2,
   parameter int DIR_OFFSET  = 'h400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [NPINS-1:0]  pwdata,
   output logic [NPINS-1:0]  prdata,
   input  logic [NPINS-1:0]  gpio_in,
   output logic [NPINS-1:0]  gpio_out,
   output logic [NPINS-1:0]  gpio_oe_n
);
   gmc_sel_e         sel;
   logic [NPINS-1:0] mask;
   logic             wr_data;
   logic             wr_dir;
   logic             rd_en;
   logic [NPINS-1:0] data_q;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] in_sync;
   logic [NPINS-1:0] pin_level;

   gmc_decode #(
      .ADDR_W(ADDR_W), .NPINS(NPINS), .MASK_LSB(MASK_LSB), .DIR_OFFSET(DIR_OFFSET)
   ) u_decode (
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .sel(sel), .mask(mask), .wr_data(wr_data), .wr_dir(wr_dir), .rd_en(rd_en)
   );

   gmc_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(gpio_in), .sync_out(in_sync)
   );

   gmc_regs #(.NPINS(NPINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_dir(wr_dir),
      .mask(mask), .wdata(pwdata), .data_q(data_q), .dir_q(dir_q)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign pin_level[p] = dir_q[p] ? data_q[p] : in_sync[p];
      assign gpio_out[p]  = dir_q[p] & data_q[p];
      assign gpio_oe_n[p] = ~dir_q[p];
   end

   always_comb begin
      prdata = '0;
      if (rd_en) begin
         unique case (sel)
            GMC_SEL_DATA: prdata = pin_level & mask;
            GMC_SEL_DIR:  prdata = dir_q;
            default:      prdata = '0;
         endcase
      end
   end

   // R3: masked-off bits of a data read are zero
   a_r3_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !pwrite && paddr[ADDR_W-1:MASK_LSB+NPINS] == '0)
         |-> ((prdata & ~paddr[MASK_LSB+NPINS-1:MASK_LSB]) == '0));
   // R10: unmapped addresses read zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !pwrite && paddr[ADDR_W-1:MASK_LSB+NPINS] != '0
        && paddr != ADDR_W'(DIR_OFFSET)) |-> (prdata == '0));
   // R6: a pad without output enable drives 0
   a_r6_off_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((gpio_out & gpio_oe_n) == '0));
   // R1: first cycle after reset everything is input
   a_r1_reset_inputs: assert property (@(posedge clk)
      !rst_n |=> (gpio_oe_n == '1));
endmodule

// File: tb/gpio_mask_ctrl_bench.sv
module gpio_mask_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [7:0]  pwdata = '0;
   logic [7:0]  prdata;
   logic [7:0]  gpio_in = '0;
   logic [7:0]  gpio_out, gpio_oe_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_data = '0, m_dir = '0, m_in = '0;

   always #2.5 clk = ~clk;

   gpio_mask_ctrl u_gpio_mask_ctrl (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpio_in(gpio_in),
      .gpio_out(gpio_out), .gpio_oe_n(gpio_oe_n)
   );

   function automatic logic [7:0] exp_read(input logic [11:0] a);
      if (a[1:0] != 2'b00) return 8'h00;
      if (a[11:10] == 2'b00) return a[9:2] & ((m_data & m_dir) | (m_in & ~m_dir));
      if (a == 12'h400) return m_dir;
      return 8'h00;
   endfunction

   function automatic void model_write(input logic [11:0] a, input logic [7:0] d);
      if (a[1:0] != 2'b00) return;
      if (a[11:10] == 2'b00) m_data = (m_data & ~a[9:2]) | (d & a[9:2]);
      else if (a == 12'h400) m_dir = d;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic apb_write(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
      model_write(a, d);
   endtask

   task automatic apb_read(input logic [11:0] a, input string req);
      @(negedge clk);
      psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge clk);
      penable = 1;
      #1 check(req, prdata, exp_read(a));
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   task automatic set_inputs(input logic [7:0] v);
      @(negedge clk);
      gpio_in = v;
      repeat (2) @(posedge clk);
      m_in = v;
   endtask

   task automatic check_pads(input string req);
      #1;
      check(req, gpio_out, m_data & m_dir);
      check(req, gpio_oe_n, ~m_dir);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1a2b3c4d));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check_pads("R1");
      apb_read(12'h400, "R1 dir");
      apb_read(12'h3FC, "R1 data");

      // R7 direction register
      apb_write(12'h400, 8'hF0);
      apb_read(12'h400, "R7");
      check_pads("R6");

      // R2/R4 masked write on output pins
      apb_write(12'h3FC, 8'hA5);
      apb_write(12'h0C0, 8'h00);          // mask 0x30
      apb_read(12'h3FC, "R2");
      apb_read(12'h300, "R4 mask C0");
      check_pads("R6");

      // R8 all-zero mask
      apb_write(12'h000, 8'hFF);
      apb_read(12'h3FC, "R8 write ignored");
      apb_read(12'h000, "R8 read zero");

      // R10 unmapped and unaligned
      apb_write(12'h404, 8'h0F);
      apb_write(12'h401, 8'h0F);
      apb_write(12'h3FD, 8'h5A);
      apb_read(12'h400, "R10 dir unchanged");
      apb_read(12'h3FC, "R10 data unchanged");
      apb_read(12'h800, "R10 read zero");

      // R9 setup phase only
      @(negedge clk);
      psel = 1; penable = 0; pwrite = 1; paddr = 12'h3FC; pwdata = 8'h00;
      @(negedge clk);
      psel = 0; pwrite = 0;
      apb_read(12'h3FC, "R9");

      // R5 exact latency with the read held open
      apb_write(12'h400, 8'h00);
      set_inputs(8'h3C);
      @(negedge clk);
      psel = 1; penable = 1; pwrite = 0; paddr = 12'h3FC; gpio_in = 8'hC3;
      @(negedge clk);
      #1 check("R5 after one edge", prdata, 8'h3C);
      @(negedge clk);
      #1 check("R5 after two edges", prdata, 8'hC3);
      psel = 0; penable = 0; m_in = 8'hC3;
      apb_read(12'h0F0, "R3 R5 masked input");

      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned op = $urandom_range(0, 5);
         logic [11:0] a;
         logic [7:0] d = 8'($urandom);
         case (op)
            0, 1: begin a = {2'b00, 8'($urandom), 2'b00}; apb_write(a, d); end
            2: apb_write(12'h400, d);
            3: begin a = {2'b00, 8'($urandom), 2'b00}; apb_read(a, "R2 R3 R4 R5 random"); end
            4: set_inputs(d);
            default: begin
               a = 12'($urandom);
               if ($urandom_range(0, 1) == 0) apb_write(a, d);
               else apb_read(a, "R10 random");
            end
         endcase
         check_pads("R6 random");
      end
      finish_run();
   end
endmodule